// File: doc/BRIEF.md
# Synchronous Burst Block Reader

This block fetches one aligned block of 32-bit words from an on-chip word store and sends it over a synchronous bus that is two words wide. The block length is a build-time choice of 4 or 16 words. The store is read in groups of four words. The first group needs a long access time. Each later group needs a short one, and that short access runs while the previous group is on the bus. Each group leaves as two 64-bit beats on consecutive cycles. A fixed number of idle cycles follows the last beat of every block, and only then is a new address taken. Because of this, every block takes an exact, known number of cycles: 45 for a 4-word block and 57 for a 16-word block with the default timing.

A requester offers a word address with a valid/ready handshake. It must hold `req_valid` and `req_addr` steady until `req_ready` is high. `req_ready` is high only when the block is fully idle, so a request raised during a transfer or during the closing idle cycles waits. It is taken on the first free cycle. The output side has no back-pressure, as a synchronous bus requires: each beat is shown for exactly one cycle with `out_valid`, and the consumer must take it then. `blk_cycles` reports the cycle count of the most recently finished block.

Top module: `burst_block_reader`

## Requirements
- R1: After reset, `req_ready` is 1 and `out_valid`, `out_last` and `blk_cycles` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1, and that cycle is the address cycle. From the next cycle, `req_ready` stays 0 until the block and its idle cycles are over.
- R3: The first beat of a block appears 41 cycles after the address cycle, which allows 40 cycles of first-group access.
- R4: Each four-word group leaves as two beats on back-to-back cycles, in rising word order. Beat j of a block carries word base+2j in bits 31:0 and word base+2j+1 in bits 63:32. There is no output ready, and no beat repeats.
- R5: The first beat of each later group comes exactly 4 cycles after the first beat of the group before it, so the next read overlaps the current transfer.
- R6: `out_last` is 1 only on the final beat of a block, and only together with `out_valid`.
- R7: Two idle cycles follow the last beat before `req_ready` returns. A request held high through them is taken on the first ready cycle. Back-to-back address cycles are therefore 45 cycles apart for 4-word blocks and 57 for 16-word blocks.
- R8: Once a block is over, `blk_cycles` reads 45 (4-word) or 57 (16-word): the address cycle through the last idle cycle.
- R9: The low log2(block words) bits of `req_addr` are ignored. The block starts at the address rounded down to a block boundary.
- R10: Store word i holds the low 32 bits of (i+1) * 0x9E3779B9. Word addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Word address of the requested block |
| out_valid | output | 1 | A 64-bit beat is on `out_data` this cycle |
| out_data | output | 2*WORD_W | Beat data, lower word address in the low half |
| out_last | output | 1 | Final beat of the block |
| blk_cycles | output | CNT_W | Cycle total of the last finished block |

## Verification
The bound checker watches the handshake and beat framing on every cycle. It checks that the block goes busy right after an accept, that ready is never high while a beat is out, that beats come in pairs of exactly two, that the last flag only rides on a valid beat, and that the cycle after a last beat is idle and not ready. Other properties need whole scenarios and are left to the bench. These are the exact 41-cycle first-beat delay, the 4-cycle group spacing, the data content and address alignment, the 45 and 57 cycle block periods under a held request, and the reported cycle totals. The bench checks them with both block sizes instantiated side by side.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int GROUP_WORDS = 4;
  localparam int BEATS_PER_GROUP = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BEAT1,
    ST_GAP
  } brc_state_e;
endpackage

// File: rtl/brc_mem_model.sv
module brc_mem_model #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int FIRST_LAT = 40,
  parameter int NEXT_LAT  = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     rd_req,
  input  logic                                     rd_first,
  input  logic [ADDR_W-1:0]                        rd_addr,
  output logic                                     grp_vld,
  output logic [brc_pkg::GROUP_WORDS*WORD_W-1:0]   grp_data
);
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int MAX_LAT   = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
  localparam int LAT_W     = $clog2(MAX_LAT + 1);
  localparam logic [63:0] MIX = 64'h0000_0000_9E37_79B9;

  logic [WORD_W-1:0] store [MEM_WORDS];
  logic [LAT_W-1:0]  lat_cnt;
  logic [ADDR_W-1:0] addr_q;

  // fixed word content, computed per index
  for (genvar gi = 0; gi < MEM_WORDS; gi++) begin : g_store
    localparam logic [63:0] PROD = 64'(gi + 1) * MIX;
    assign store[gi] = PROD[WORD_W-1:0];
  end

  // latency counter: request in cycle r gives grp_vld in cycle r+LAT
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      addr_q   <= '0;
      grp_vld  <= 1'b0;
      grp_data <= '0;
    end else begin
      grp_vld <= 1'b0;
      if (rd_req) begin
        lat_cnt <= rd_first ? LAT_W'(FIRST_LAT - 1) : LAT_W'(NEXT_LAT - 1);
        addr_q  <= rd_addr;
      end else if (lat_cnt != '0) begin
        lat_cnt <= lat_cnt - 1'b1;
        if (lat_cnt == LAT_W'(1)) begin
          grp_vld <= 1'b1;
          for (int w = 0; w < brc_pkg::GROUP_WORDS; w++) begin
            grp_data[w*WORD_W +: WORD_W] <= store[addr_q + ADDR_W'(w)];
          end
        end
      end
    end
  end
endmodule

// File: rtl/brc_seq.sv
module brc_seq #(
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int BLOCK_WORDS = 16,
  parameter int IDLE_CYC    = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  input  logic [ADDR_W-1:0]                        req_addr,
  output logic                                     req_ready,
  input  logic                                     grp_vld,
  input  logic [brc_pkg::GROUP_WORDS*WORD_W-1:0]   grp_data,
  output logic                                     rd_req,
  output logic                                     rd_first,
  output logic [ADDR_W-1:0]                        rd_addr,
  output logic                                     out_valid,
  output logic [2*WORD_W-1:0]                      out_data,
  output logic                                     out_last,
  output logic                                     blk_start,
  output logic                                     blk_end
);
  import brc_pkg::*;

  localparam int GROUPS = BLOCK_WORDS / GROUP_WORDS;
  localparam int GI_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int GAP_W  = $clog2(IDLE_CYC + 1);
  localparam int HALF_W = BEATS_PER_GROUP * WORD_W;
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(BLOCK_WORDS - 1);

  brc_state_e        st;
  logic [GI_W-1:0]   grp_idx;
  logic [ADDR_W-1:0] base;
  logic [GAP_W-1:0]  gap_cnt;
  logic              start_q;
  logic              beat0;
  logic              last_grp;

  assign req_ready = (st == ST_IDLE);
  assign blk_start = req_ready && req_valid;
  assign blk_end   = (st == ST_GAP) && (gap_cnt == '0);
  assign beat0     = (st == ST_WAIT) && grp_vld;
  assign last_grp  = (grp_idx == GI_W'(GROUPS - 1));

  // first read one cycle after the address cycle, later reads overlap beats
  assign rd_req   = start_q || (beat0 && !last_grp);
  assign rd_first = start_q;
  assign rd_addr  = start_q ? base
                            : base + ADDR_W'((32'(grp_idx) + 1) * GROUP_WORDS);

  assign out_valid = beat0 || (st == ST_BEAT1);
  assign out_last  = (st == ST_BEAT1) && last_grp;
  assign out_data  = (st == ST_BEAT1) ? grp_data[2*HALF_W-1:HALF_W]
                                      : grp_data[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      grp_idx <= '0;
      base    <= '0;
      gap_cnt <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            base    <= req_addr & ALIGN;
            grp_idx <= '0;
            start_q <= 1'b1;
            st      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (grp_vld) st <= ST_BEAT1;
        end
        ST_BEAT1: begin
          if (last_grp) begin
            gap_cnt <= GAP_W'(IDLE_CYC - 1);
            st      <= ST_GAP;
          end else begin
            grp_idx <= grp_idx + 1'b1;
            st      <= ST_WAIT;
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) st <= ST_IDLE;
          else gap_cnt <= gap_cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brc_cyc_meter.sv
module brc_cyc_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             blk_end,
  output logic [CNT_W-1:0] blk_cycles
);
  logic [CNT_W-1:0] run_cnt;

  // run_cnt holds the 1-based index of the current cycle within the block
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      blk_cycles <= '0;
    end else begin
      if (blk_start) run_cnt <= CNT_W'(2);
      else run_cnt <= run_cnt + 1'b1;
      if (blk_end) blk_cycles <= run_cnt;
    end
  end
endmodule

// File: rtl/burst_block_reader.sv
module burst_block_reader #(
  parameter int BLOCK_WORDS = 16,
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 32,
  parameter int FIRST_LAT   = 40,
  parameter int NEXT_LAT    = 4,
  parameter int IDLE_CYC    = 2,
  parameter int CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                out_valid,
  output logic [2*WORD_W-1:0] out_data,
  output logic                out_last,
  output logic [CNT_W-1:0]    blk_cycles
);
  localparam int GRP_W = brc_pkg::GROUP_WORDS * WORD_W;

  logic              rd_req;
  logic              rd_first;
  logic [ADDR_W-1:0] rd_addr;
  logic              grp_vld;
  logic [GRP_W-1:0]  grp_data;
  logic              blk_start;
  logic              blk_end;

  brc_mem_model #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)
  ) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_first(rd_first), .rd_addr(rd_addr),
    .grp_vld(grp_vld), .grp_data(grp_data)
  );

  brc_seq #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .BLOCK_WORDS(BLOCK_WORDS), .IDLE_CYC(IDLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .grp_vld(grp_vld), .grp_data(grp_data),
    .rd_req(rd_req), .rd_first(rd_first), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .blk_start(blk_start), .blk_end(blk_end)
  );

  brc_cyc_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .blk_start(blk_start), .blk_end(blk_end),
    .blk_cycles(blk_cycles)
  );
endmodule

// File: rtl/brc_chk.sv
module brc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic out_valid,
  input logic out_last
);
  // R6
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid)
    else $error("last flag without a beat");

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready)
    else $error("still ready after an accept");

  // R2
  no_ready_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready)
    else $error("ready while a beat is out");

  // R4
  beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid)
    else $error("beat not followed by its partner");

  // R4
  pair_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |=> !out_valid)
    else $error("more than two beats in a row");

  // R7
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!req_ready && !out_valid))
    else $error("no idle cycle after the last beat");
endmodule

bind burst_block_reader brc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .out_valid(out_valid), .out_last(out_last)
);

// File: tb/burst_block_reader_bench.sv
module burst_block_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_addr = '0;

  logic        r4, v4, l4, r16, v16, l16;
  logic [63:0] d4, d16;
  logic [7:0]  c4, c16;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // inst 0: 4-word blocks, inst 1: 16-word blocks
  logic [63:0] bd [2][512];
  int          bc [2][512];
  bit          bl [2][512];
  int          nb [2];
  int          hs [2][64];
  int          nh [2];

  localparam logic [5:0] ADDRS [6] = '{6'd0, 6'd16, 6'd48, 6'd35, 6'd60, 6'd7};

  always #5 clk = ~clk;

  burst_block_reader #(.BLOCK_WORDS(16)) u_burst_block_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r16),
    .req_addr(req_addr), .out_valid(v16), .out_data(d16), .out_last(l16),
    .blk_cycles(c16)
  );

  burst_block_reader #(.BLOCK_WORDS(4)) u_burst_block_reader_b4 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r4),
    .req_addr(req_addr), .out_valid(v4), .out_data(d4), .out_last(l4),
    .blk_cycles(c4)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    nb[0] = 0; nb[1] = 0; nh[0] = 0; nh[1] = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (v4) begin
        if (nb[0] < 512) begin bd[0][nb[0]] = d4; bc[0][nb[0]] = cyc; bl[0][nb[0]] = l4; end
        nb[0]++;
      end
      if (v16) begin
        if (nb[1] < 512) begin bd[1][nb[1]] = d16; bc[1][nb[1]] = cyc; bl[1][nb[1]] = l16; end
        nb[1]++;
      end
      if (req_valid && r4) begin
        if (nh[0] < 64) hs[0][nh[0]] = cyc;
        nh[0]++;
      end
      if (req_valid && r16) begin
        if (nh[1] < 64) hs[1][nh[1]] = cyc;
        nh[1]++;
      end
    end
  end

  function automatic logic [31:0] wv(input int i);
    logic [63:0] p;
    p = 64'((i % 64) + 1) * 64'h9E37_79B9;
    return p[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_block(input int inst, input int s, input int k, input logic [5:0] a);
    int bw, g, base, h, got;
    bw = inst ? 16 : 4;
    g = bw / 4;
    base = int'(a) & ~(bw - 1);
    chk(nh[inst] == k + 1, "R2", "accept count", 64'(nh[inst] - k), 64'd1);
    h = (nh[inst] > k && k < 64) ? hs[inst][k] : 0;
    got = nb[inst] - s;
    chk(got == 2 * g, "R4", "beat count", 64'(got), 64'(2 * g));
    for (int j = 0; j < 2 * g; j++) begin
      if (j < got && s + j < 512) begin
        int ec;
        logic [63:0] ed;
        ec = h + 41 + 4 * (j / 2) + (j % 2);
        chk(bc[inst][s + j] == ec, (j == 0) ? "R3" : "R5", "beat cycle",
            64'(bc[inst][s + j] - h), 64'(ec - h));
        ed = {wv(base + 2 * j + 1), wv(base + 2 * j)};
        chk(bd[inst][s + j] == ed, (int'(a) != base) ? "R9" : "R10", "beat data",
            bd[inst][s + j], ed);
        chk(bl[inst][s + j] == (j == 2 * g - 1), "R6", "last flag",
            64'(bl[inst][s + j]), 64'(j == 2 * g - 1));
      end
    end
    chk((inst ? c16 : c4) == (inst ? 8'd57 : 8'd45), "R8", "block cycles",
        64'(inst ? c16 : c4), inst ? 64'd57 : 64'd45);
  endtask

  task automatic run_block(input logic [5:0] a);
    int s0, s1, k0, k1;
    s0 = nb[0]; s1 = nb[1]; k0 = nh[0]; k1 = nh[1];
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(!r4 && !r16, "R2", "ready while busy", 64'({r4, r16}), 64'd0);
    repeat (60) @(posedge clk);
    #1;
    check_block(0, s0, k0, a);
    check_block(1, s1, k1, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k0, k1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(r4 && r16, "R1", "ready after reset", 64'({r4, r16}), 64'd3);
    chk(!v4 && !v16, "R1", "valid after reset", 64'({v4, v16}), 64'd0);
    chk(!l4 && !l16, "R1", "last after reset", 64'({l4, l16}), 64'd0);
    chk(c4 == 8'd0 && c16 == 8'd0, "R1", "cycles after reset", 64'({c4, c16}), 64'd0);

    for (int i = 0; i < 6; i++) run_block(ADDRS[i]);

    // R7 request held through idle cycles: accepted on first ready cycle
    k0 = nh[0]; k1 = nh[1];
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = 6'd20;
    while (nh[1] < k1 + 3) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(hs[0][k0] == hs[1][k1], "R2", "same accept cycle",
        64'(hs[0][k0]), 64'(hs[1][k1]));
    chk(hs[0][k0 + 1] - hs[0][k0] == 45, "R7", "4-word period 1",
        64'(hs[0][k0 + 1] - hs[0][k0]), 64'd45);
    chk(hs[0][k0 + 2] - hs[0][k0 + 1] == 45, "R7", "4-word period 2",
        64'(hs[0][k0 + 2] - hs[0][k0 + 1]), 64'd45);
    chk(hs[1][k1 + 1] - hs[1][k1] == 57, "R7", "16-word period 1",
        64'(hs[1][k1 + 1] - hs[1][k1]), 64'd57);
    chk(hs[1][k1 + 2] - hs[1][k1 + 1] == 57, "R7", "16-word period 2",
        64'(hs[1][k1 + 2] - hs[1][k1 + 1]), 64'd57);
    repeat (70) @(posedge clk);
    @(negedge clk);
    chk(c4 == 8'd45, "R8", "4-word total after burst", 64'(c4), 64'd45);
    chk(c16 == 8'd57, "R8", "16-word total after burst", 64'(c16), 64'd57);
    chk(r4 && r16, "R7", "ready after final gap", 64'({r4, r16}), 64'd3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule